// File: doc/BRIEF.md
# Power-of-Two Address Bus Tester

This block is a hardware sequencer that looks for stuck or shorted address lines in a memory region. It drives a simple synchronous single-port memory and detects overlapping locations. A start pulse latches a base address and a region size. The size is given as a count of address bits. The block then touches only offset zero and the power-of-two offsets inside the region. It first fills each of them with an alternating-bit pattern. Then it takes each tested offset in turn. It writes the complement there and reads back every other tested offset. If one of those reads returns the complement, an address line has made two locations alias.

The block must only be started after the data lines have been verified, because it trusts every value it reads back. Upper address bits above the region come from the base address and are never varied. A parameter gives a number of low address bits that do not select a distinct word, and those bits are never varied either. The result is a one-cycle done pulse with a pass flag. On failure the block also reports the offset it had just written and the offset where the complement showed up.

Top module: `addr_bus_tester`

## Requirements
- R1: Every memory access goes to base + offset, where offset is 0 or 2^k with SKIP <= k < min(region_bits, AW); no other offset is ever issued.
- R2: The low SKIP address bits and every bit at or above the region size are never varied. A stuck line among them has no effect on the result.
- R3: The fill pattern has bit i equal to i mod 2 (0xAA for 8 bits, 0xAAAA for 16 bits), and the test value is its bitwise complement. After a passing run, every tested location holds the fill pattern again.
- R4: Order: fill all tested offsets in ascending order. Then, for each test offset in ascending order: write the complement, read every other tested offset in ascending order, and write the fill pattern back.
- R5: Read data is taken one cycle after the read request.
- R6: A read that returns the complement ends the run with pass_o = 0. It reports the offset just written and the offset that was read, and it stops at the first such read.
- R7: A run that sees no complement ends with pass_o = 1. pass_o and both fault offsets hold their values until the next accepted start.
- R8: done_o is a one-cycle pulse. A passing run raises it exactly M*(M+4) cycles after the start edge, where M is the number of tested offsets.
- R9: start_i is ignored while a run is busy. Changes on base_addr_i or region_bits_i during a run also have no effect.
- R10: After reset the block is idle: no memory access, with done_o, pass_o, busy_o and both fault offsets at 0.
- R11: When region_bits_i <= SKIP, only offset 0 is tested (M = 1). Values above AW are treated as AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| base_addr_i | input | AW | Region base, aligned to the region size |
| region_bits_i | input | $clog2(AW+1) | Region size as a count of address bits |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Read data, valid one cycle after a read request |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run found no overlap |
| fault_wr_off_o | output | AW | Offset written with the complement when a fault was seen |
| fault_rd_off_o | output | AW | Offset that returned the complement |

## Verification
Every result appears together with done_o. For a passing run that is M*(M+4) edges after the start edge: M fill cycles, then M+3 cycles per test offset. A failing run ends on the cycle after the offending read data returns, so the fail point depends on where the overlap sits in the read order. The bench drives inputs and samples outputs on falling edges. It counts falling edges after the start edge until done_o shows high, then compares that count and the result outputs against values worked out per vector from the offset order. It checks that done_o has dropped one cycle later and inspects its own memory model for the restored pattern.

// File: rtl/abt_pkg.sv
package abt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_FLIP,
        ST_SCAN,
        ST_DRAIN,
        ST_MEND
    } abt_state_e;

endpackage

// File: rtl/abt_offset_gen.sv
// Maps a tested-offset index to its offset: index 0 is offset 0,
// index j >= 1 is 2^(SKIP+j-1).
module abt_offset_gen #(
    parameter int AW   = 16,
    parameter int SKIP = 0,
    parameter int IW   = 5
) (
    input  logic [IW-1:0] idx_i,
    output logic [AW-1:0] offset_o
);

    always_comb begin
        offset_o = '0;
        if (idx_i != '0) begin
            offset_o = AW'(1) << (SKIP + int'(idx_i) - 1);
        end
    end

endmodule

// File: rtl/abt_alias_cmp.sv
// Tags each read request with its index and compares the returning data
// against the complement pattern one cycle later.
module abt_alias_cmp #(
    parameter int DW = 8,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [IW-1:0] issue_idx_i,
    input  logic [DW-1:0] rdata_i,
    input  logic [DW-1:0] inv_i,
    output logic          hit_o,
    output logic [IW-1:0] hit_idx_o
);

    typedef struct packed {
        logic          vld;
        logic [IW-1:0] idx;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d.vld = issue_i;
        pend_d.idx = issue_i ? issue_idx_i : pend_q.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign hit_o     = pend_q.vld && (rdata_i == inv_i);
    assign hit_idx_o = pend_q.idx;

endmodule

// File: rtl/addr_bus_tester.sv
module addr_bus_tester
    import abt_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 8,
    parameter int SKIP = 0,
    localparam int RBW = $clog2(AW + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [AW-1:0]  base_addr_i,
    input  logic [RBW-1:0] region_bits_i,
    output logic           mem_en_o,
    output logic           mem_we_o,
    output logic [AW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_wdata_o,
    input  logic [DW-1:0]  mem_rdata_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           pass_o,
    output logic [AW-1:0]  fault_wr_off_o,
    output logic [AW-1:0]  fault_rd_off_o
);

    localparam int IW = ((AW - SKIP + 1) > 1) ? $clog2(AW - SKIP + 1) : 1;

    function automatic logic [DW-1:0] alt_pattern();
        logic [DW-1:0] p;
        for (int i = 0; i < DW; i++) begin
            p[i] = (i % 2) == 1;
        end
        return p;
    endfunction

    localparam logic [DW-1:0] FILL_PAT = alt_pattern();
    localparam logic [DW-1:0] FLIP_PAT = ~FILL_PAT;

    typedef struct packed {
        abt_state_e    st;
        logic [AW-1:0] base;
        logic [IW-1:0] last;
        logic [IW-1:0] tix;
        logic [IW-1:0] cix;
        logic          done;
        logic          pass;
        logic [IW-1:0] f_wr;
        logic [IW-1:0] f_rd;
    } ctl_t;

    ctl_t d, q;

    logic [RBW-1:0] rb_clamp;
    logic [IW-1:0]  last_idx;
    logic [IW-1:0]  sel_idx;
    logic [AW-1:0]  sel_off;
    logic           rd_issue;
    logic           hit;
    logic [IW-1:0]  hit_idx;
    logic           en_c;
    logic           we_c;
    logic [DW-1:0]  wdata_c;
    logic [AW-1:0]  base_lat;

    // Region size clamp and index of the highest tested offset
    always_comb begin
        rb_clamp = (int'(region_bits_i) > AW) ? RBW'(AW) : region_bits_i;
        last_idx = (int'(rb_clamp) > SKIP) ? IW'(int'(rb_clamp) - SKIP) : '0;
    end

    abt_offset_gen #(.AW(AW), .SKIP(SKIP), .IW(IW)) u_off_sel (
        .idx_i    (sel_idx),
        .offset_o (sel_off)
    );

    abt_offset_gen #(.AW(AW), .SKIP(SKIP), .IW(IW)) u_off_wr (
        .idx_i    (q.f_wr),
        .offset_o (fault_wr_off_o)
    );

    abt_offset_gen #(.AW(AW), .SKIP(SKIP), .IW(IW)) u_off_rd (
        .idx_i    (q.f_rd),
        .offset_o (fault_rd_off_o)
    );

    abt_alias_cmp #(.DW(DW), .IW(IW)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (rd_issue),
        .issue_idx_i (q.cix),
        .rdata_i     (mem_rdata_i),
        .inv_i       (FLIP_PAT),
        .hit_o       (hit),
        .hit_idx_o   (hit_idx)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        en_c     = 1'b0;
        we_c     = 1'b0;
        wdata_c  = FILL_PAT;
        sel_idx  = q.cix;
        rd_issue = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st   = ST_FILL;
                    d.base = base_addr_i;
                    d.last = last_idx;
                    d.tix  = '0;
                    d.cix  = '0;
                    d.pass = 1'b0;
                    d.f_wr = '0;
                    d.f_rd = '0;
                end
            end
            ST_FILL: begin
                en_c    = 1'b1;
                we_c    = 1'b1;
                wdata_c = FILL_PAT;
                sel_idx = q.cix;
                if (q.cix == q.last) begin
                    d.cix = '0;
                    d.st  = ST_FLIP;
                end else begin
                    d.cix = q.cix + 1'b1;
                end
            end
            ST_FLIP: begin
                en_c    = 1'b1;
                we_c    = 1'b1;
                wdata_c = FLIP_PAT;
                sel_idx = q.tix;
                d.cix   = '0;
                d.st    = ST_SCAN;
            end
            ST_SCAN: begin
                if (hit) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.pass = 1'b0;
                    d.f_wr = q.tix;
                    d.f_rd = hit_idx;
                end else begin
                    if (q.cix != q.tix) begin
                        en_c     = 1'b1;
                        sel_idx  = q.cix;
                        rd_issue = 1'b1;
                    end
                    if (q.cix == q.last) begin
                        d.st = ST_DRAIN;
                    end else begin
                        d.cix = q.cix + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (hit) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.pass = 1'b0;
                    d.f_wr = q.tix;
                    d.f_rd = hit_idx;
                end else begin
                    d.st = ST_MEND;
                end
            end
            ST_MEND: begin
                en_c    = 1'b1;
                we_c    = 1'b1;
                wdata_c = FILL_PAT;
                sel_idx = q.tix;
                if (q.tix == q.last) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.pass = 1'b1;
                end else begin
                    d.tix = q.tix + 1'b1;
                    d.st  = ST_FLIP;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_en_o    = en_c;
    assign mem_we_o    = we_c;
    assign mem_wdata_o = wdata_c;
    assign mem_addr_o  = q.base + sel_off;
    assign busy_o      = (q.st != ST_IDLE);
    assign done_o      = q.done;
    assign pass_o      = q.pass;
    assign base_lat    = q.base;

endmodule

// File: rtl/abt_sva.sv
module abt_sva #(
    parameter int AW   = 16,
    parameter int DW   = 8,
    parameter int SKIP = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          mem_en_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          pass_o,
    input logic [AW-1:0] fault_wr_off_o,
    input logic [AW-1:0] fault_rd_off_o,
    input logic [AW-1:0] base_lat
);

    function automatic logic [DW-1:0] alt_pattern();
        logic [DW-1:0] p;
        for (int i = 0; i < DW; i++) begin
            p[i] = (i % 2) == 1;
        end
        return p;
    endfunction

    localparam logic [DW-1:0] FILL_PAT = alt_pattern();
    localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << SKIP) - 64'd1);

    logic [AW-1:0] rel_addr;
    assign rel_addr = mem_addr_o - base_lat;

    a_r1_pow2_offset: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |-> $onehot0(rel_addr));

    a_r2_low_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |-> ((rel_addr & LOW_MASK) == '0));

    a_r3_write_values: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_wdata_o == FILL_PAT || mem_wdata_o == ~FILL_PAT));

    a_r3_write_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_en_o);

    a_r6_fault_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !pass_o) |-> (fault_wr_off_o != fault_rd_off_o));

    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(fault_wr_off_o)
                                   && $stable(fault_rd_off_o)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_en_o);

endmodule

bind addr_bus_tester abt_sva #(.AW(AW), .DW(DW), .SKIP(SKIP)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .mem_en_o       (mem_en_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .pass_o         (pass_o),
    .fault_wr_off_o (fault_wr_off_o),
    .fault_rd_off_o (fault_rd_off_o),
    .base_lat       (base_lat)
);

// File: tb/addr_bus_tester_tb_top.sv
module addr_bus_tester_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 12;
    localparam int DW   = 16;
    localparam int SKIP = 1;
    localparam int RBW  = $clog2(AW + 1);
    localparam logic [DW-1:0] FILL = 16'hAAAA;
    localparam logic [DW-1:0] FLIP = 16'h5555;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [AW-1:0]  base_addr = '0;
    logic [RBW-1:0] region_bits = '0;
    logic           mem_en, mem_we;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic [DW-1:0]  mem_rdata = '0;
    logic           busy, done, pass;
    logic [AW-1:0]  f_wr, f_rd;

    int n_chk  = 0;
    int n_fail = 0;

    // Fault model: 0 none, 1 stuck-at-0 on bit fa, 2 stuck-at-1 on bit fa,
    // 3 wired-OR short between bits fa and fb
    int fmode = 0;
    int fa = 0;
    int fb = 0;

    logic [DW-1:0] mem [0:(1<<AW)-1];
    logic          log_on = 1'b0;
    logic [AW-1:0] wlog_a [0:127];
    logic [DW-1:0] wlog_d [0:127];
    logic [AW-1:0] rlog_a [0:127];
    int nw = 0;
    int nr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_bus_tester #(.AW(AW), .DW(DW), .SKIP(SKIP)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .base_addr_i    (base_addr),
        .region_bits_i  (region_bits),
        .mem_en_o       (mem_en),
        .mem_we_o       (mem_we),
        .mem_addr_o     (mem_addr),
        .mem_wdata_o    (mem_wdata),
        .mem_rdata_i    (mem_rdata),
        .busy_o         (busy),
        .done_o         (done),
        .pass_o         (pass),
        .fault_wr_off_o (f_wr),
        .fault_rd_off_o (f_rd)
    );

    function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
        logic [AW-1:0] p;
        logic          s;
        p = a;
        s = a[fa] | a[fb];
        case (fmode)
            1: p[fa] = 1'b0;
            2: p[fa] = 1'b1;
            3: begin p[fa] = s; p[fb] = s; end
            default: ;
        endcase
        return p;
    endfunction

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[phys(mem_addr)] <= mem_wdata;
            else        mem_rdata <= mem[phys(mem_addr)];
            if (log_on) begin
                if (mem_we && nw < 128) begin
                    wlog_a[nw] = mem_addr; wlog_d[nw] = mem_wdata; nw++;
                end else if (!mem_we && nr < 128) begin
                    rlog_a[nr] = mem_addr; nr++;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int count_m(input int rb);
        int r;
        r = (rb > AW) ? AW : rb;
        return (r > SKIP) ? (r - SKIP + 1) : 1;
    endfunction

    function automatic logic [AW-1:0] off_of(input int i);
        return (i == 0) ? '0 : AW'(1) << (SKIP + i - 1);
    endfunction

    // Runs one test; lat = edges from start edge until done seen, -1 on timeout.
    // restart_at > 0 pulses start again and scrambles inputs at that cycle.
    task automatic run_one(input logic [RBW-1:0] rb, input logic [AW-1:0] base,
                           input int restart_at, output int lat);
        @(negedge clk);
        region_bits = rb;
        base_addr   = base;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 0;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
            start = (lat == restart_at);
            if (lat == restart_at) begin
                base_addr   = 12'hFFF;
                region_bits = 4'd2;
            end
        end
        start = 1'b0;
        if (!done) lat = -1;
    endtask

    typedef struct packed {
        logic [3:0]  rb;
        logic [11:0] base;
        logic [1:0]  fm;
        logic [3:0]  fa;
        logic [3:0]  fb;
        logic        ep;
        logic [11:0] ew;
        logic [11:0] es;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd6,  12'h040, 2'd0, 4'd0,  4'd0, 1'b1, 12'h000, 12'h000, 4'd7},
        '{4'd6,  12'h000, 2'd1, 4'd3,  4'd0, 1'b0, 12'h000, 12'h008, 4'd6},
        '{4'd6,  12'h000, 2'd2, 4'd2,  4'd0, 1'b0, 12'h000, 12'h004, 4'd6},
        '{4'd6,  12'h000, 2'd3, 4'd3,  4'd5, 1'b0, 12'h008, 12'h020, 4'd6},
        '{4'd4,  12'h800, 2'd3, 4'd1,  4'd2, 1'b0, 12'h002, 12'h004, 4'd6},
        '{4'd6,  12'h000, 2'd2, 4'd0,  4'd0, 1'b1, 12'h000, 12'h000, 4'd2},
        '{4'd6,  12'h000, 2'd1, 4'd6,  4'd0, 1'b1, 12'h000, 12'h000, 4'd2},
        '{4'd1,  12'h100, 2'd0, 4'd0,  4'd0, 1'b1, 12'h000, 12'h000, 4'd11},
        '{4'd0,  12'h200, 2'd1, 4'd1,  4'd0, 1'b1, 12'h000, 12'h000, 4'd11},
        '{4'd12, 12'h000, 2'd0, 4'd0,  4'd0, 1'b1, 12'h000, 12'h000, 4'd1},
        '{4'd15, 12'h000, 2'd0, 4'd0,  4'd0, 1'b1, 12'h000, 12'h000, 4'd11},
        '{4'd15, 12'h000, 2'd1, 4'd11, 4'd0, 1'b0, 12'h000, 12'h800, 4'd11}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lat;
        int m;
        int bad;
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 busy in reset", 32'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 done after reset", 32'(done), 0);
        chk("R10 pass after reset", 32'(pass), 0);
        chk("R10 busy after reset", 32'(busy), 0);
        chk("R10 mem_en after reset", 32'(mem_en), 0);
        chk("R10 fault offsets after reset", {8'd0, f_wr, f_rd}, 0);

        // Vector table: R1 R2 R6 R7 R8 R11 (tag in req field)
        for (int v = 0; v < NV; v++) begin
            fmode = int'(VECS[v].fm);
            fa    = int'(VECS[v].fa);
            fb    = int'(VECS[v].fb);
            run_one(VECS[v].rb, VECS[v].base, 0, lat);
            chk($sformatf("R%0d vec%0d pass_o", VECS[v].req, v), 32'(pass), 32'(VECS[v].ep));
            if (VECS[v].ep) begin
                m = count_m(int'(VECS[v].rb));
                chk($sformatf("R8 vec%0d latency", v), 32'(lat), 32'(m * (m + 4)));
                if (fmode == 0) begin
                    bad = 0;
                    for (int i = 0; i < m; i++)
                        if (mem[VECS[v].base + off_of(i)] !== FILL) bad++;
                    chk($sformatf("R3 vec%0d restored fill", v), 32'(bad), 0);
                end
            end else begin
                chk($sformatf("R6 vec%0d written offset", v), 32'(f_wr), 32'(VECS[v].ew));
                chk($sformatf("R6 vec%0d seen offset", v), 32'(f_rd), 32'(VECS[v].es));
            end
            @(negedge clk);
            chk($sformatf("R8 vec%0d done one cycle", v), 32'(done), 0);
            chk($sformatf("R7 vec%0d result held", v), 32'(pass), 32'(VECS[v].ep));
        end

        // R4 and R3: access order and data for a 4-offset region at 0x800
        fmode = 0;
        nw = 0; nr = 0;
        log_on = 1'b1;
        run_one(4'd4, 12'h800, 0, lat);
        log_on = 1'b0;
        m = count_m(4);
        chk("R4 write count", 32'(nw), 32'(m + 2 * m));
        chk("R4 read count", 32'(nr), 32'(m * (m - 1)));
        bad = 0;
        for (int i = 0; i < m; i++) begin
            if (wlog_a[i] !== 12'h800 + off_of(i) || wlog_d[i] !== FILL) bad++;
        end
        for (int t = 0; t < m; t++) begin
            if (wlog_a[m + 2*t] !== 12'h800 + off_of(t) || wlog_d[m + 2*t] !== FLIP) bad++;
            if (wlog_a[m + 2*t + 1] !== 12'h800 + off_of(t) || wlog_d[m + 2*t + 1] !== FILL) bad++;
        end
        chk("R4 write order and R3 values", 32'(bad), 0);
        bad = 0;
        begin
            int k;
            k = 0;
            for (int t = 0; t < m; t++)
                for (int c = 0; c < m; c++)
                    if (c != t) begin
                        if (rlog_a[k] !== 12'h800 + off_of(c)) bad++;
                        k++;
                    end
        end
        chk("R4 read order", 32'(bad), 0);

        // R9: restart and input changes mid-run are ignored
        run_one(4'd6, 12'h000, 10, lat);
        chk("R9 latency with start while busy", 32'(lat), 60);
        chk("R9 pass with start while busy", 32'(pass), 1);
        bad = 0;
        for (int i = 0; i < 6; i++) if (mem[off_of(i)] !== FILL) bad++;
        chk("R9 original base still used", 32'(bad), 0);

        // R5: overlap found on the last read of a sweep (drain cycle)
        fmode = 1; fa = 5; fb = 0;
        run_one(4'd6, 12'h000, 0, lat);
        chk("R5 late overlap pass_o", 32'(pass), 0);
        chk("R5 late overlap seen offset", 32'(f_rd), 32'h020);
        chk("R5 late overlap written offset", 32'(f_wr), 32'h000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule